// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block sits next to the receive and transmit queues of one UART channel and turns its interrupt sources into one identification code and one level interrupt line. The sources are the receive line errors, a receive timeout, receive data at its trigger level, transmitter space, modem input change, flow-control character detection and a hardware handshake line dropping to inactive. Each source is masked by its enable bit. The code of the highest-priority source that is both pending and enabled is presented, and the interrupt line is raised while any such source exists.

Pulsed sources are held in sticky flags until their own clearing event arrives: a status register read, a holding register read or write, or an identification read that returns that source's code. The line-error source is not a flag. It is a count of erroneous characters currently stored in the receive queue, and it is kept up to date from push, pop and flush events. The block also reports the error bits of the character at the queue head, forced to zero when the queue is empty.

A source event and its clearing event in the same cycle leave the source pending. The code and the interrupt line are combinational from the registered state and the level inputs, so both follow a change one clock edge after the event.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, `irq_id` is 6'b000001, `irq` is 0 and `rx_err_any` is 0.
- R2: The codes are line status 6'b000110, RX timeout 6'b001100, RX data 6'b000100, transmitter 6'b000010, modem 6'b000000, flow character 6'b010000, handshake drop 6'b100000 and none 6'b000001. The priority order, highest first, is line status, RX timeout, RX data, transmitter, modem, flow character, handshake drop.
- R3: `rx_err_any` is 1 while at least one stored character carries an error. A push with `rx_push_err`=1 adds one. An `rhr_rd` with `rx_empty`=0 and `rx_head_err`≠0 removes one. `rx_flush` clears the count. A set `rx_err_any` raises line status when `ien[2]`=1.
- R4: An `ovr_evt` pulse raises line status until `lsr_rd`.
- R5: An `tmo_evt` pulse raises RX timeout until `rhr_rd`. RX data follows the level `rx_trig`.
- R6: A `thr_evt` pulse raises the transmitter source. It is cleared by `thr_wr`, or by `iir_rd` while the transmitter code is shown. An `iir_rd` while another code is shown leaves it pending.
- R7: An `msr_evt` pulse raises the modem source until `msr_rd`.
- R8: `xoff_det` raises the flow-character source until `xon_det`. `spec_det` raises the same code until an `iir_rd` while that code is shown. `xon_det` does not clear the `spec_det` cause.
- R9: `flow_drop` raises the handshake-drop source until an `iir_rd` while its code is shown.
- R10: `rx_head_err_o` equals `rx_head_err` when `rx_empty`=0 and is 3'b000 when `rx_empty`=1.
- R11: The enable bits map as follows: `ien[0]` covers RX timeout and RX data, `ien[1]` the transmitter, `ien[2]` line status, `ien[3]` modem, `ien[4]` flow character and `ien[5]` handshake drop. A disabled source affects neither `irq` nor `irq_id`, but it stays latched. With `ien`=0 (polled), `irq` is 0.
- R12: `irq` is 1 exactly when some enabled source is pending, and `irq_id[0]` = !`irq`. A set event and a clear event in the same cycle leave the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien | input | 6 | Source enable bits (see R11) |
| rx_push | input | 1 | A character enters the receive queue |
| rx_push_err | input | 1 | That character has a parity, framing or break error |
| rx_flush | input | 1 | Receive queue cleared |
| rx_empty | input | 1 | Receive queue is empty |
| rx_head_err | input | 3 | Error bits stored with the head character |
| rx_trig | input | 1 | Receive level at or above trigger (level) |
| ovr_evt | input | 1 | Overrun pulse |
| tmo_evt | input | 1 | Receive timeout pulse |
| thr_evt | input | 1 | Transmitter space pulse |
| msr_evt | input | 1 | Modem input change pulse |
| xoff_det | input | 1 | Stop character detected |
| xon_det | input | 1 | Resume character detected |
| spec_det | input | 1 | Special character detected |
| flow_drop | input | 1 | Handshake line went inactive |
| iir_rd | input | 1 | Identification register read |
| lsr_rd | input | 1 | Line status read |
| rhr_rd | input | 1 | Receive holding read (pops the head) |
| msr_rd | input | 1 | Modem status read |
| thr_wr | input | 1 | Transmit holding write |
| irq_id | output | 6 | Identification code |
| irq | output | 1 | Level interrupt |
| rx_err_any | output | 1 | An erroneous character is stored |
| rx_head_err_o | output | 3 | Head character error bits, zero when empty |

## Verification
The bench builds the block with a queue depth of 4. At that depth the error counter can be filled to its limit and then flushed within a few cycles, which tests the counter's upper boundary as well as the return to zero. The same sequences apply at depth 64, where only the counter width changes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int ID_W = 6;
    localparam logic [ID_W-1:0] ID_NONE = 6'b000001;
    localparam logic [ID_W-1:0] ID_LINE = 6'b000110;
    localparam logic [ID_W-1:0] ID_TMO  = 6'b001100;
    localparam logic [ID_W-1:0] ID_RXD  = 6'b000100;
    localparam logic [ID_W-1:0] ID_THR  = 6'b000010;
    localparam logic [ID_W-1:0] ID_MSR  = 6'b000000;
    localparam logic [ID_W-1:0] ID_XOFF = 6'b010000;
    localparam logic [ID_W-1:0] ID_FLOW = 6'b100000;

    // Sticky flag slots
    localparam int F_OVR  = 0;
    localparam int F_TMO  = 1;
    localparam int F_THR  = 2;
    localparam int F_MSR  = 3;
    localparam int F_XOFF = 4;
    localparam int F_SPEC = 5;
    localparam int F_FLOW = 6;
    localparam int NFLAG  = 7;

    // Encoder request slots, index 0 is highest priority
    localparam int NREQ = 7;
endpackage

// File: rtl/irq_sticky.sv
// Bank of sticky interrupt flags.
// Assumes set and clear are single-cycle qualified strobes; set wins.
module irq_sticky #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    // Hold each flag from its set strobe until its clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= set | (q & ~clr);
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
                set[i] |=> q[i]);
            p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !set[i]) |=> !q[i]);
        end
    endgenerate
endmodule

// File: rtl/rx_err_tracker.sv
// Counts erroneous characters held in the receive queue.
// Assumes pops on an empty queue are ignored and the queue never
// holds more than DEPTH characters.
module rx_err_tracker #(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       push_err,
    input  logic       pop,
    input  logic       empty,
    input  logic [2:0] head_err,
    input  logic       flush,
    output logic       any_err,
    output logic [2:0] head_err_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] MAXC = CW'(DEPTH);

    logic [CW-1:0] cnt;
    logic          inc, dec;

    // Decode count adjustments from queue traffic
    always_comb begin
        inc = push && push_err && (cnt != MAXC);
        dec = pop && !empty && (head_err != 3'b000) && (cnt != '0);
    end

    // Maintain the error count; flush dominates
    always_ff @(posedge clk) begin
        if (!rst_n || flush) cnt <= '0;
        else if (inc && !dec) cnt <= cnt + 1'b1;
        else if (dec && !inc) cnt <= cnt - 1'b1;
    end

    assign any_err    = (cnt != '0);
    assign head_err_o = empty ? 3'b000 : head_err;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAXC);
    p_flush_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !any_err);
    p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (head_err_o == 3'b000));
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder from masked requests to identification code.
// Assumes req[0] is the highest priority.
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    output logic [ID_W-1:0] id,
    output logic [NREQ-1:0] grant
);
    // Pick the first request in priority order
    always_comb begin
        grant = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i] && (grant == '0)) grant[i] = 1'b1;
        end
    end

    // Map the winner to its code
    always_comb begin
        unique case (1'b1)
            grant[0]: id = ID_LINE;
            grant[1]: id = ID_TMO;
            grant[2]: id = ID_RXD;
            grant[3]: id = ID_THR;
            grant[4]: id = ID_MSR;
            grant[5]: id = ID_XOFF;
            grant[6]: id = ID_FLOW;
            default:  id = ID_NONE;
        endcase
    end

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/uart_irq_prio.sv
// Collects UART channel interrupt sources, masks them and reports the
// highest-priority pending one. Assumes event inputs are one-cycle pulses.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] ien,
    input  logic       rx_push,
    input  logic       rx_push_err,
    input  logic       rx_flush,
    input  logic       rx_empty,
    input  logic [2:0] rx_head_err,
    input  logic       rx_trig,
    input  logic       ovr_evt,
    input  logic       tmo_evt,
    input  logic       thr_evt,
    input  logic       msr_evt,
    input  logic       xoff_det,
    input  logic       xon_det,
    input  logic       spec_det,
    input  logic       flow_drop,
    input  logic       iir_rd,
    input  logic       lsr_rd,
    input  logic       rhr_rd,
    input  logic       msr_rd,
    input  logic       thr_wr,
    output logic [5:0] irq_id,
    output logic       irq,
    output logic       rx_err_any,
    output logic [2:0] rx_head_err_o
);
    logic [NFLAG-1:0] fset, fclr, flag;
    logic [NREQ-1:0]  req, grant;
    logic [ID_W-1:0]  id;

    rx_err_tracker #(.DEPTH(DEPTH)) u_err (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_err(rx_push_err),
        .pop(rhr_rd), .empty(rx_empty), .head_err(rx_head_err),
        .flush(rx_flush), .any_err(rx_err_any), .head_err_o(rx_head_err_o)
    );

    // Route source events and their clearing events to the flag bank
    always_comb begin
        fset = '0;
        fclr = '0;
        fset[F_OVR]  = ovr_evt;   fclr[F_OVR]  = lsr_rd;
        fset[F_TMO]  = tmo_evt;   fclr[F_TMO]  = rhr_rd;
        fset[F_THR]  = thr_evt;   fclr[F_THR]  = thr_wr || (iir_rd && id == ID_THR);
        fset[F_MSR]  = msr_evt;   fclr[F_MSR]  = msr_rd;
        fset[F_XOFF] = xoff_det;  fclr[F_XOFF] = xon_det;
        fset[F_SPEC] = spec_det;  fclr[F_SPEC] = iir_rd && id == ID_XOFF;
        fset[F_FLOW] = flow_drop; fclr[F_FLOW] = iir_rd && id == ID_FLOW;
    end

    irq_sticky #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(fset), .clr(fclr), .q(flag)
    );

    // Mask pending sources into priority-ordered requests
    always_comb begin
        req[0] = ien[2] && (rx_err_any || flag[F_OVR]);
        req[1] = ien[0] && flag[F_TMO];
        req[2] = ien[0] && rx_trig;
        req[3] = ien[1] && flag[F_THR];
        req[4] = ien[3] && flag[F_MSR];
        req[5] = ien[4] && (flag[F_XOFF] || flag[F_SPEC]);
        req[6] = ien[5] && flag[F_FLOW];
    end

    irq_prio_enc u_enc (
        .clk(clk), .rst_n(rst_n), .req(req), .id(id), .grant(grant)
    );

    assign irq_id = id;
    assign irq    = |req;

    p_int_vs_id_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !irq_id[0]);
    p_polled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 6'b0) |-> !irq);
    p_thr_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_evt) |=> !flag[F_THR]);
endmodule

// File: tb/test_uart_irq_prio.sv
module test_uart_irq_prio;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] ien = '0;
    logic rx_push = 0, rx_push_err = 0, rx_flush = 0, rx_empty = 1, rx_trig = 0;
    logic [2:0] rx_head_err = '0;
    logic ovr_evt = 0, tmo_evt = 0, thr_evt = 0, msr_evt = 0;
    logic xoff_det = 0, xon_det = 0, spec_det = 0, flow_drop = 0;
    logic iir_rd = 0, lsr_rd = 0, rhr_rd = 0, msr_rd = 0, thr_wr = 0;
    logic [5:0] irq_id;
    logic irq, rx_err_any;
    logic [2:0] rx_head_err_o;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_prio #(.DEPTH(4)) i_uart_irq_prio (
        .clk(clk), .rst_n(rst_n), .ien(ien), .rx_push(rx_push),
        .rx_push_err(rx_push_err), .rx_flush(rx_flush), .rx_empty(rx_empty),
        .rx_head_err(rx_head_err), .rx_trig(rx_trig), .ovr_evt(ovr_evt),
        .tmo_evt(tmo_evt), .thr_evt(thr_evt), .msr_evt(msr_evt),
        .xoff_det(xoff_det), .xon_det(xon_det), .spec_det(spec_det),
        .flow_drop(flow_drop), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
        .rhr_rd(rhr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr),
        .irq_id(irq_id), .irq(irq), .rx_err_any(rx_err_any),
        .rx_head_err_o(rx_head_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drop all pulses at the falling edge, after the rising edge took them
    task automatic step();
        @(negedge clk);
        {rx_push, rx_push_err, rx_flush, ovr_evt, tmo_evt, thr_evt, msr_evt} = '0;
        {xoff_det, xon_det, spec_det, flow_drop, iir_rd, lsr_rd, rhr_rd, msr_rd, thr_wr} = '0;
    endtask

    task automatic t_reset();
        chk("R1 id", irq_id, 6'b000001);
        chk("R1 irq", irq, 0);
        chk("R1 err", rx_err_any, 0);
    endtask

    task automatic t_priority();
        ien = 6'h3F;
        ovr_evt = 1; tmo_evt = 1; rx_trig = 1; thr_evt = 1; msr_evt = 1;
        xoff_det = 1; flow_drop = 1; step();
        chk("R2 line first", irq_id, 6'b000110);
        chk("R12 irq", irq, 1);
        lsr_rd = 1; step();
        chk("R4 overrun cleared -> tmo", irq_id, 6'b001100);
        rhr_rd = 1; step();
        chk("R5 tmo cleared -> rx data", irq_id, 6'b000100);
        rx_trig = 0; step();
        chk("R5 rx data level gone -> thr", irq_id, 6'b000010);
        thr_wr = 1; step();
        chk("R6 thr write -> modem", irq_id, 6'b000000);
        msr_rd = 1; step();
        chk("R7 msr read -> xoff", irq_id, 6'b010000);
        xon_det = 1; step();
        chk("R8 xon -> flow drop", irq_id, 6'b100000);
        iir_rd = 1; step();
        chk("R9 iir read clears flow", irq_id, 6'b000001);
        chk("R12 irq low", irq, 0);
    endtask

    task automatic t_err_track();
        rx_empty = 0;
        rx_push = 1; rx_push_err = 1; step();
        rx_push = 1; step();
        rx_push = 1; rx_push_err = 1; step();
        chk("R3 err set", rx_err_any, 1);
        chk("R3 line id", irq_id, 6'b000110);
        rx_head_err = 3'b100; rhr_rd = 1; step();
        chk("R3 one left", rx_err_any, 1);
        rx_head_err = 3'b000; rhr_rd = 1; step();
        chk("R3 clean pop keeps", rx_err_any, 1);
        rx_head_err = 3'b010; rhr_rd = 1; step();
        chk("R3 last err popped", rx_err_any, 0);
        chk("R3 id none", irq_id, 6'b000001);
        for (int i = 0; i < 4; i++) begin
            rx_push = 1; rx_push_err = 1; step();
        end
        rx_flush = 1; step();
        chk("R3 flush clears", rx_err_any, 0);
        rx_head_err = 3'b000; rx_empty = 1;
    endtask

    task automatic t_head();
        rx_head_err = 3'b111; rx_empty = 1; #1;
        chk("R10 empty zero", rx_head_err_o, 3'b000);
        rx_empty = 0; #1;
        chk("R10 head passes", rx_head_err_o, 3'b111);
        rx_empty = 1; rx_head_err = 3'b000; #1;
    endtask

    task automatic t_thr_iir();
        tmo_evt = 1; thr_evt = 1; step();
        iir_rd = 1; step();
        chk("R6 iir on tmo keeps thr", irq_id, 6'b001100);
        rhr_rd = 1; step();
        chk("R6 thr visible", irq_id, 6'b000010);
        iir_rd = 1; step();
        chk("R6 iir clears thr", irq_id, 6'b000001);
    endtask

    task automatic t_xoff();
        spec_det = 1; step();
        chk("R8 special", irq_id, 6'b010000);
        xon_det = 1; step();
        chk("R8 xon leaves special", irq_id, 6'b010000);
        iir_rd = 1; step();
        chk("R8 iir clears special", irq_id, 6'b000001);
        xoff_det = 1; step();
        iir_rd = 1; step();
        chk("R8 iir leaves xoff", irq_id, 6'b010000);
        xon_det = 1; step();
        chk("R8 xon clears xoff", irq_id, 6'b000001);
    endtask

    task automatic t_mask();
        ien = 6'h00;
        thr_evt = 1; msr_evt = 1; ovr_evt = 1; step();
        chk("R11 polled irq", irq, 0);
        chk("R11 polled id", irq_id, 6'b000001);
        ien = 6'b001000; #1;
        chk("R11 modem latched", irq_id, 6'b000000);
        ien = 6'b001010; #1;
        chk("R11 thr over modem", irq_id, 6'b000010);
        ien = 6'h3F; #1;
        chk("R11 line unmasked", irq_id, 6'b000110);
        lsr_rd = 1; thr_wr = 1; msr_rd = 1; step();
        chk("R11 all cleared", irq, 0);
    endtask

    task automatic t_set_wins();
        msr_evt = 1; msr_rd = 1; step();
        chk("R12 set wins", irq_id, 6'b000000);
        msr_rd = 1; step();
        chk("R12 then cleared", irq_id, 6'b000001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_err_track();
        t_head();
        t_thr_iir();
        t_xoff();
        t_mask();
        t_set_wins();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule